// File: doc/BRIEF.md
# Two-State Snooping Cache Controller

This block keeps one core's small write-through cache coherent with the caches of other cores on a shared broadcast bus. Every transaction on that bus has a single global order that all controllers observe. Each cache line is either Valid or Invalid, and nothing else. Loads that hit a Valid line are answered from the local copy without touching the bus. Loads that miss fetch the word from memory with a shared-read request (GETS). Every store is written through to memory with an exclusive-write request (GETX), and stores never allocate a line.

The controller watches the transactions that other controllers place on the bus. An exclusive write by another core to a word held locally invalidates that line. Shared reads by other cores are ignored. The cache is direct-mapped, with one data word per line, and uses word addresses.

The block requests the bus from an external arbiter and holds the request until a one-cycle grant arrives. The processor side uses a valid/ready handshake and gets a single-cycle response pulse when each operation completes.

Top module: `snoop_vi_cache`

## Requirements
- R1: After reset, every line is Invalid, `cpu_req_ready` is 1, and `bus_req` and `cpu_rsp_valid` are 0.
- R2: A load whose index holds a Valid line with a matching tag raises `cpu_rsp_valid` in the cycle after acceptance, with the stored word, and puts no transaction on the bus.
- R3: A load that misses issues a GETS (`bus_cmd_op`=0) at the load's word address. It returns `mem_rsp_data` as its result, and the line is then Valid for later loads.
- R4: A store to a Valid matching line issues a GETX (`bus_cmd_op`=1) that carries the store's address and data. The line stays Valid and holds the new word.
- R5: A store to a line that is not Valid or whose tag differs issues the same GETX but does not allocate. The line is left as it was.
- R6: A snooped GETS (`snp_op`=0) from another core changes no line.
- R7: A snooped GETX (`snp_op`=1) whose index and tag match a Valid line makes that line Invalid. A GETX with the same index but a different tag leaves the line alone.
- R8: A snooped GETX to the same address in the same cycle that a load is accepted is ordered first, so the load misses and issues a GETS.
- R9: A snooped GETX to the address of a load whose GETS has already been granted does not stop the load from returning its fill data. The line nevertheless stays Invalid.
- R10: A snooped GETX that invalidates a line between a store's acceptance and its grant is not undone by that store. The line remains Invalid.
- R11: `cpu_req_ready` is 0 from the acceptance of a miss or store until its response. While `bus_req` waits for `bus_gnt`, `bus_req` and the command address stay constant.
- R12: Lines are direct-mapped on the low 4 address bits. A missing load with a different tag replaces the line, so the previous tag misses afterwards.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_req_valid | input | 1 | Processor request present |
| cpu_req_ready | output | 1 | Controller can accept a request |
| cpu_req_we | input | 1 | 1 = store, 0 = load |
| cpu_req_addr | input | 10 | Word address |
| cpu_req_wdata | input | 32 | Store data |
| cpu_rsp_valid | output | 1 | One-cycle completion pulse |
| cpu_rsp_rdata | output | 32 | Load result |
| bus_req | output | 1 | Request to the bus arbiter |
| bus_gnt | input | 1 | One-cycle grant; this controller owns the bus in that cycle |
| bus_cmd_valid | output | 1 | This controller's transaction is on the bus |
| bus_cmd_op | output | 1 | 0 = GETS, 1 = GETX |
| bus_cmd_addr | output | 10 | Transaction word address |
| bus_cmd_data | output | 32 | Write-through data for GETX |
| mem_rsp_valid | input | 1 | Memory returns data for this controller's GETS |
| mem_rsp_data | input | 32 | Returned word |
| snp_valid | input | 1 | Another core's transaction is on the bus |
| snp_op | input | 1 | 0 = GETS, 1 = GETX |
| snp_addr | input | 10 | Snooped word address |

## Verification
The embedded checks assume a well-behaved environment: a grant never coincides with another core's snooped transaction, grants arrive only while `bus_req` is high, and memory data arrives only while a fill is outstanding. The bench's arbiter and memory models respect all three conditions. Snoops are injected only in cycles where no grant is pending, using a controllable grant delay. The ordering corners (R8, R9, R10) are reached by scheduling a snoop in the acceptance cycle, after the GETS grant, or before the store grant.

// File: rtl/vi_cache_pkg.sv
package vi_cache_pkg;

    typedef enum logic {
        OP_GETS = 1'b0,
        OP_GETX = 1'b1
    } bus_op_e;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_ARB  = 2'd1,
        ST_FILL = 2'd2
    } ctrl_st_e;

endpackage

// File: rtl/vi_line_array.sv
module vi_line_array #(
    parameter int LINES  = 16,
    parameter int TAG_W  = 6,
    parameter int DATA_W = 32,
    localparam int IDX_W = $clog2(LINES)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [IDX_W-1:0]  lk_idx,
    input  logic [TAG_W-1:0]  lk_tag,
    output logic              lk_hit,
    output logic [DATA_W-1:0] lk_data,
    input  logic [IDX_W-1:0]  sn_idx,
    input  logic [TAG_W-1:0]  sn_tag,
    output logic              sn_hit,
    input  logic              inval_en,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic [TAG_W-1:0]  wr_tag,
    input  logic [DATA_W-1:0] wr_data
);

    typedef struct packed {
        logic [LINES-1:0]             vld;
        logic [LINES-1:0][TAG_W-1:0]  tag;
        logic [LINES-1:0][DATA_W-1:0] dat;
    } arr_t;

    arr_t arr_d, arr_q;

    assign lk_hit  = arr_q.vld[lk_idx] && (arr_q.tag[lk_idx] == lk_tag);
    assign lk_data = arr_q.dat[lk_idx];
    assign sn_hit  = arr_q.vld[sn_idx] && (arr_q.tag[sn_idx] == sn_tag);

    always_comb begin
        arr_d = arr_q;
        // invalidation first; a same-index fill is later in bus order
        if (inval_en) begin
            arr_d.vld[sn_idx] = 1'b0;
        end
        if (wr_en) begin
            arr_d.vld[wr_idx] = 1'b1;
            arr_d.tag[wr_idx] = wr_tag;
            arr_d.dat[wr_idx] = wr_data;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            arr_q <= '0;
        end else begin
            arr_q <= arr_d;
        end
    end

    // R7
    snoop_inval_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (inval_en && !(wr_en && wr_idx == sn_idx)) |=> !arr_q.vld[$past(sn_idx)]);

    // R1
    reset_clear_chk: assert property (@(posedge clk)
        $rose(rst_n) |-> (arr_q.vld == '0));

endmodule

// File: rtl/vi_ctrl.sv
module vi_ctrl
    import vi_cache_pkg::*;
#(
    parameter int ADDR_W = 10,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cpu_req_valid,
    output logic              cpu_req_ready,
    input  logic              cpu_req_we,
    input  logic [ADDR_W-1:0] cpu_req_addr,
    input  logic [DATA_W-1:0] cpu_req_wdata,
    output logic              cpu_rsp_valid,
    output logic [DATA_W-1:0] cpu_rsp_rdata,
    output logic [ADDR_W-1:0] lk_addr,
    input  logic              lk_hit,
    input  logic [DATA_W-1:0] lk_data,
    output logic              wr_en,
    output logic [ADDR_W-1:0] wr_addr,
    output logic [DATA_W-1:0] wr_data,
    output logic              bus_req,
    input  logic              bus_gnt,
    output logic              bus_cmd_valid,
    output logic              bus_cmd_op,
    output logic [ADDR_W-1:0] bus_cmd_addr,
    output logic [DATA_W-1:0] bus_cmd_data,
    input  logic              mem_rsp_valid,
    input  logic [DATA_W-1:0] mem_rsp_data,
    input  logic              snp_valid,
    input  logic              snp_op,
    input  logic [ADDR_W-1:0] snp_addr
);

    typedef struct packed {
        ctrl_st_e          st;
        logic              we;
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] wdata;
        logic              kill;
        logic              rsp_v;
        logic [DATA_W-1:0] rsp_d;
    } ctl_t;

    ctl_t ctl_d, ctl_q;

    logic snp_x;
    logic kill_accept;
    logic kill_pend;

    assign snp_x       = snp_valid && (snp_op == OP_GETX);
    assign kill_accept = snp_x && (snp_addr == cpu_req_addr);
    assign kill_pend   = snp_x && (snp_addr == ctl_q.addr);

    assign lk_addr = (ctl_q.st == ST_IDLE) ? cpu_req_addr : ctl_q.addr;

    always_comb begin
        ctl_d       = ctl_q;
        ctl_d.rsp_v = 1'b0;
        wr_en       = 1'b0;
        wr_addr     = ctl_q.addr;
        wr_data     = ctl_q.wdata;
        unique case (ctl_q.st)
            ST_IDLE: begin
                if (cpu_req_valid) begin
                    ctl_d.we    = cpu_req_we;
                    ctl_d.addr  = cpu_req_addr;
                    ctl_d.wdata = cpu_req_wdata;
                    ctl_d.kill  = 1'b0;
                    if (!cpu_req_we && lk_hit && !kill_accept) begin
                        ctl_d.rsp_v = 1'b1;
                        ctl_d.rsp_d = lk_data;
                    end else begin
                        ctl_d.st = ST_ARB;
                    end
                end
            end
            ST_ARB: begin
                if (bus_gnt) begin
                    if (ctl_q.we) begin
                        ctl_d.rsp_v = 1'b1;
                        ctl_d.st    = ST_IDLE;
                        wr_en       = lk_hit;
                    end else begin
                        ctl_d.st   = ST_FILL;
                        ctl_d.kill = 1'b0;
                    end
                end
            end
            ST_FILL: begin
                if (kill_pend) begin
                    ctl_d.kill = 1'b1;
                end
                if (mem_rsp_valid) begin
                    ctl_d.rsp_v = 1'b1;
                    ctl_d.rsp_d = mem_rsp_data;
                    ctl_d.st    = ST_IDLE;
                    wr_en       = !(ctl_q.kill || kill_pend);
                    wr_data     = mem_rsp_data;
                end
            end
            default: ctl_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctl_q <= '0;
        end else begin
            ctl_q <= ctl_d;
        end
    end

    assign cpu_req_ready = (ctl_q.st == ST_IDLE);
    assign cpu_rsp_valid = ctl_q.rsp_v;
    assign cpu_rsp_rdata = ctl_q.rsp_d;
    assign bus_req       = (ctl_q.st == ST_ARB);
    assign bus_cmd_valid = bus_req && bus_gnt;
    assign bus_cmd_op    = ctl_q.we;
    assign bus_cmd_addr  = ctl_q.addr;
    assign bus_cmd_data  = ctl_q.wdata;

    // R11
    req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_req && !bus_gnt) |=> (bus_req && $stable(bus_cmd_addr)));

    // R11
    ready_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bus_req |-> !cpu_req_ready);

    // R2
    hit_no_bus_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_req_ready && cpu_req_valid && !cpu_req_we && lk_hit && !snp_x)
            |=> (cpu_rsp_valid && !bus_req));

    // R8
    gnt_vs_snoop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bus_gnt |-> (!snp_valid && bus_req));

    // R3
    fill_only_pending_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_rsp_valid |-> (ctl_q.st == ST_FILL));

endmodule

// File: rtl/snoop_vi_cache.sv
module snoop_vi_cache
    import vi_cache_pkg::*;
#(
    parameter int ADDR_W = 10,
    parameter int DATA_W = 32,
    parameter int LINES  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cpu_req_valid,
    output logic              cpu_req_ready,
    input  logic              cpu_req_we,
    input  logic [ADDR_W-1:0] cpu_req_addr,
    input  logic [DATA_W-1:0] cpu_req_wdata,
    output logic              cpu_rsp_valid,
    output logic [DATA_W-1:0] cpu_rsp_rdata,
    output logic              bus_req,
    input  logic              bus_gnt,
    output logic              bus_cmd_valid,
    output logic              bus_cmd_op,
    output logic [ADDR_W-1:0] bus_cmd_addr,
    output logic [DATA_W-1:0] bus_cmd_data,
    input  logic              mem_rsp_valid,
    input  logic [DATA_W-1:0] mem_rsp_data,
    input  logic              snp_valid,
    input  logic              snp_op,
    input  logic [ADDR_W-1:0] snp_addr
);

    localparam int IDX_W = $clog2(LINES);
    localparam int TAG_W = ADDR_W - IDX_W;

    logic [ADDR_W-1:0] lk_addr;
    logic              lk_hit;
    logic [DATA_W-1:0] lk_data;
    logic              sn_hit;
    logic              inval_en;
    logic              wr_en;
    logic [ADDR_W-1:0] wr_addr;
    logic [DATA_W-1:0] wr_data;

    assign inval_en = snp_valid && (snp_op == OP_GETX) && sn_hit;

    vi_ctrl #(
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W)
    ) ctrl_i (
        .clk           (clk),
        .rst_n         (rst_n),
        .cpu_req_valid (cpu_req_valid),
        .cpu_req_ready (cpu_req_ready),
        .cpu_req_we    (cpu_req_we),
        .cpu_req_addr  (cpu_req_addr),
        .cpu_req_wdata (cpu_req_wdata),
        .cpu_rsp_valid (cpu_rsp_valid),
        .cpu_rsp_rdata (cpu_rsp_rdata),
        .lk_addr       (lk_addr),
        .lk_hit        (lk_hit),
        .lk_data       (lk_data),
        .wr_en         (wr_en),
        .wr_addr       (wr_addr),
        .wr_data       (wr_data),
        .bus_req       (bus_req),
        .bus_gnt       (bus_gnt),
        .bus_cmd_valid (bus_cmd_valid),
        .bus_cmd_op    (bus_cmd_op),
        .bus_cmd_addr  (bus_cmd_addr),
        .bus_cmd_data  (bus_cmd_data),
        .mem_rsp_valid (mem_rsp_valid),
        .mem_rsp_data  (mem_rsp_data),
        .snp_valid     (snp_valid),
        .snp_op        (snp_op),
        .snp_addr      (snp_addr)
    );

    vi_line_array #(
        .LINES  (LINES),
        .TAG_W  (TAG_W),
        .DATA_W (DATA_W)
    ) lines_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .lk_idx   (lk_addr[IDX_W-1:0]),
        .lk_tag   (lk_addr[ADDR_W-1:IDX_W]),
        .lk_hit   (lk_hit),
        .lk_data  (lk_data),
        .sn_idx   (snp_addr[IDX_W-1:0]),
        .sn_tag   (snp_addr[ADDR_W-1:IDX_W]),
        .sn_hit   (sn_hit),
        .inval_en (inval_en),
        .wr_en    (wr_en),
        .wr_idx   (wr_addr[IDX_W-1:0]),
        .wr_tag   (wr_addr[ADDR_W-1:IDX_W]),
        .wr_data  (wr_data)
    );

    // R5
    store_no_alloc_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_cmd_valid && bus_cmd_op == OP_GETX && !lk_hit) |-> !wr_en);

endmodule

// File: tb/snoop_vi_cache_tb_top.sv
module snoop_vi_cache_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cpu_req_valid = 1'b0;
    logic        cpu_req_ready;
    logic        cpu_req_we = 1'b0;
    logic [9:0]  cpu_req_addr = '0;
    logic [31:0] cpu_req_wdata = '0;
    logic        cpu_rsp_valid;
    logic [31:0] cpu_rsp_rdata;
    logic        bus_req;
    logic        bus_gnt = 1'b0;
    logic        bus_cmd_valid;
    logic        bus_cmd_op;
    logic [9:0]  bus_cmd_addr;
    logic [31:0] bus_cmd_data;
    logic        mem_rsp_valid = 1'b0;
    logic [31:0] mem_rsp_data = '0;
    logic        snp_valid = 1'b0;
    logic        snp_op = 1'b0;
    logic [9:0]  snp_addr = '0;

    always #4 clk = ~clk;

    snoop_vi_cache dut_i (
        .clk(clk), .rst_n(rst_n),
        .cpu_req_valid(cpu_req_valid), .cpu_req_ready(cpu_req_ready),
        .cpu_req_we(cpu_req_we), .cpu_req_addr(cpu_req_addr),
        .cpu_req_wdata(cpu_req_wdata), .cpu_rsp_valid(cpu_rsp_valid),
        .cpu_rsp_rdata(cpu_rsp_rdata), .bus_req(bus_req), .bus_gnt(bus_gnt),
        .bus_cmd_valid(bus_cmd_valid), .bus_cmd_op(bus_cmd_op),
        .bus_cmd_addr(bus_cmd_addr), .bus_cmd_data(bus_cmd_data),
        .mem_rsp_valid(mem_rsp_valid), .mem_rsp_data(mem_rsp_data),
        .snp_valid(snp_valid), .snp_op(snp_op), .snp_addr(snp_addr)
    );

    int errors = 0;
    int checks = 0;

    logic [31:0] mem [1024];
    int          n_gets = 0;
    int          n_getx = 0;
    logic [9:0]  last_addr;
    logic [31:0] last_data;
    logic [31:0] fill_word;
    int          fill_cnt = -1;
    int          grant_delay = 1;
    int          gwait = 0;
    int          fill_delay = 2;

    logic        ref_vld [16];
    logic [5:0]  ref_tag [16];

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic bit ref_hit(input logic [9:0] a);
        return ref_vld[a[3:0]] && ref_tag[a[3:0]] == a[9:4];
    endfunction

    // memory and bus monitor
    always @(posedge clk) begin
        if (bus_cmd_valid) begin
            last_addr <= bus_cmd_addr;
            last_data <= bus_cmd_data;
            if (bus_cmd_op) begin
                n_getx++;
                mem[bus_cmd_addr] = bus_cmd_data;
            end else begin
                n_gets++;
                fill_word = mem[bus_cmd_addr];
                fill_cnt  = fill_delay;
            end
        end
    end

    // arbiter and memory response
    always @(negedge clk) begin
        bus_gnt       = 1'b0;
        mem_rsp_valid = 1'b0;
        if (bus_req) begin
            if (gwait >= grant_delay) begin
                bus_gnt = 1'b1;
                gwait   = 0;
            end else begin
                gwait++;
            end
        end else begin
            gwait = 0;
        end
        if (fill_cnt == 0) begin
            mem_rsp_valid = 1'b1;
            mem_rsp_data  = fill_word;
            fill_cnt      = -1;
        end else if (fill_cnt > 0) begin
            fill_cnt--;
        end
    end

    // snoop from another core, one cycle, at the current negedge
    task automatic snoop(input logic op, input logic [9:0] a, input logic [31:0] d);
        snp_valid = 1'b1;
        snp_op    = op;
        snp_addr  = a;
        if (op) begin
            mem[a] = d;
            if (ref_hit(a)) ref_vld[a[3:0]] = 1'b0;
        end
        @(negedge clk);
        snp_valid = 1'b0;
    endtask

    // mode: 0 plain, 1 snoop GETX in accept cycle, 2 snoop GETX after GETS grant
    task automatic do_load(input logic [9:0] a, input int mode, input logic [31:0] sdat, input string req);
        int          g0;
        bit          exp_hit;
        logic [31:0] exp_d;
        bit          sent;
        int          n;
        g0 = n_gets;
        sent = 0;
        exp_hit = ref_hit(a) && mode != 1;
        cpu_req_valid = 1'b1;
        cpu_req_we    = 1'b0;
        cpu_req_addr  = a;
        if (mode == 1) begin
            snp_valid = 1'b1; snp_op = 1'b1; snp_addr = a;
            mem[a] = sdat;
            ref_vld[a[3:0]] = ref_hit(a) ? 1'b0 : ref_vld[a[3:0]];
        end
        exp_d = mem[a];
        @(posedge clk);
        @(negedge clk);
        cpu_req_valid = 1'b0;
        snp_valid     = 1'b0;
        if (exp_hit) begin
            check(cpu_rsp_valid && !bus_req, {req, " hit one-cycle response"},
                  32'(cpu_rsp_valid), 32'd1);
        end else begin
            check(!cpu_req_ready && bus_req, "R11 ready low during miss",
                  32'(cpu_req_ready), 32'd0);
        end
        n = 0;
        while (!cpu_rsp_valid && n < 100) begin
            if (mode == 2 && !sent && n_gets > g0 && fill_cnt > 0) begin
                sent = 1;
                snoop(1'b1, a, sdat);
            end else begin
                @(negedge clk);
            end
            n++;
        end
        check(cpu_rsp_valid, {req, " load completes"}, 32'(cpu_rsp_valid), 32'd1);
        check(cpu_rsp_rdata == exp_d, {req, " load data"}, cpu_rsp_rdata, exp_d);
        check((n_gets - g0) == (exp_hit ? 0 : 1), {req, " GETS count"},
              32'(n_gets - g0), exp_hit ? 32'd0 : 32'd1);
        if (!exp_hit) begin
            check(last_addr == a, "R3 GETS address", 32'(last_addr), 32'(a));
            if (mode != 2) begin
                ref_vld[a[3:0]] = 1'b1;
                ref_tag[a[3:0]] = a[9:4];
            end
        end
        @(negedge clk);
    endtask

    // mode 1: snoop GETX to the store's address before the grant
    task automatic do_store(input logic [9:0] a, input logic [31:0] d, input int mode, input string req);
        int x0;
        int n;
        x0 = n_getx;
        cpu_req_valid = 1'b1;
        cpu_req_we    = 1'b1;
        cpu_req_addr  = a;
        cpu_req_wdata = d;
        @(posedge clk);
        @(negedge clk);
        cpu_req_valid = 1'b0;
        cpu_req_we    = 1'b0;
        check(!cpu_req_ready, "R11 ready low during store", 32'(cpu_req_ready), 32'd0);
        if (mode == 1) snoop(1'b1, a, 32'hDEAD0000 ^ 32'(a));
        n = 0;
        while (!cpu_rsp_valid && n < 100) begin
            @(negedge clk);
            n++;
        end
        check(cpu_rsp_valid, {req, " store completes"}, 32'(cpu_rsp_valid), 32'd1);
        check((n_getx - x0) == 1, {req, " one GETX"}, 32'(n_getx - x0), 32'd1);
        check(last_addr == a && last_data == d, {req, " GETX payload"}, last_data, d);
        @(negedge clk);
    endtask

    // watchdog
    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog expired (all requirements) actual=hang expected=done");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        for (int i = 0; i < 1024; i++) mem[i] = (32'(i) * 32'h00010003) ^ 32'h5A5A0000;
        for (int i = 0; i < 16; i++) begin ref_vld[i] = 1'b0; ref_tag[i] = '0; end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check(cpu_req_ready && !bus_req && !cpu_rsp_valid, "R1 reset outputs",
              {29'd0, cpu_req_ready, bus_req, cpu_rsp_valid}, 32'd4);

        for (int k = 0; k < 16; k++) begin
            logic [9:0] a;
            logic [9:0] b;
            a = {6'(k + 1), 4'(k)};
            b = {6'(k + 33), 4'(k)};
            grant_delay = k % 3;
            fill_delay  = 1 + (k % 4);
            do_load(a, 0, '0, "R3");
            do_load(a, 0, '0, "R2");
            do_store(a, 32'hC0DE0000 | 32'(k), 0, "R4");
            do_load(a, 0, '0, "R4");
            snoop(1'b0, a, '0);
            do_load(a, 0, '0, "R6");
            snoop(1'b1, b, 32'h0B0B0000 | 32'(k));
            do_load(a, 0, '0, "R7 tag mismatch");
            snoop(1'b1, a, 32'h0A0A0000 | 32'(k));
            do_load(a, 0, '0, "R7 invalidated");
            do_store(b, 32'h57000000 | 32'(k), 0, "R5");
            do_load(a, 0, '0, "R5 line unchanged");
            do_load(b, 0, '0, "R12 replace");
            do_load(a, 0, '0, "R12 old tag");
        end

        // ordering corners
        grant_delay = 1;
        fill_delay  = 4;
        for (int k = 0; k < 16; k++) begin
            logic [9:0] a;
            a = {6'(k + 7), 4'(k)};
            do_load(a, 0, '0, "R3");
            do_load(a, 1, 32'h88000000 | 32'(k), "R8");
            do_load(a, 0, '0, "R8 refill hit");
            snoop(1'b1, a, 32'h99000000 | 32'(k));
            do_load(a, 2, 32'h77000000 | 32'(k), "R9");
            do_load(a, 0, '0, "R9 line stays invalid");
            grant_delay = 4;
            do_store(a, 32'h66000000 | 32'(k), 1, "R10");
            ref_vld[a[3:0]] = 1'b0;
            do_load(a, 0, '0, "R10 line stays invalid");
            grant_delay = 1;
        end

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule